// File: doc/BRIEF.md
# Dual Stack Pointer Engine

This block keeps two stacks for a small 8-bit controller in one 256-byte data RAM that has a byte-wide port. The return stack holds the state saved by a subroutine call. Each entry is two bytes holding a 12-bit program counter and four flag bits. The operand stack holds single bytes for push and pop. The two stacks grow in opposite directions: the return-stack pointer counts upward, and the operand-stack pointer pre-decrements. Because the operand-stack pointer starts at zero, the first byte pushed lands at the highest RAM address.

An instruction sequencer drives one strobe for each operation: call, return, push, pop, or exchange of the operand-stack pointer with the accumulator. With the strobe it supplies the program counter, the flags and a data byte. The engine produces the RAM address, the write data and the read/write enables. The RAM is synchronous, and read data appears one cycle after the read enable. The engine gives back the restored program counter and the popped byte, each with a one-cycle done pulse. Call and return each need two RAM cycles, and `busy_o` marks the second of them. A firmware routine can move the operand stack away from other RAM users by exchanging a new pointer value into it.

Top module: `dual_stack_engine`

## Requirements
- R1: A call accepted in cycle T writes PC[7:0] to address PSP in cycle T. In cycle T+1 it writes the byte {flags[3:0], PC[11:8]} to PSP+1. Both bytes use the PC and flags sampled in cycle T. PSP then rises by 2.
- R2: A return accepted in cycle T reads address PSP-1 in cycle T and PSP-2 in cycle T+1, and PSP then falls by 2. In cycle T+3, `pc_o` shows {bits [3:0] of the byte read from PSP-1, the byte read from PSP-2} and `ret_done_o` is high for that one cycle. The flag nibble stored with the entry is discarded.
- R3: An accepted push writes `data_i` to address DSP-1 in the strobe cycle, and DSP becomes DSP-1.
- R4: An accepted pop reads address DSP in the strobe cycle, and DSP becomes DSP+1. Two cycles after the strobe, `pop_data_o` holds the byte read and `pop_done_o` is high for one cycle.
- R5: After reset, DSP and PSP are 0 and `busy_o`, `ret_done_o` and `pop_done_o` are low. The first push therefore writes address 0xFF, and the first call writes addresses 0x00 and 0x01.
- R6: `dsp_o` always presents the current DSP. An accepted exchange loads DSP with `data_i` on the next clock and makes no RAM access.
- R7: `busy_o` is high for exactly the one cycle that follows an accepted call or return. Strobes present while `busy_o` is high are ignored.
- R8: When several strobes are high together, only one is accepted, in the priority order call, return, push, pop, exchange.
- R9: Both pointers wrap modulo 256. A pop at DSP 0xFF leaves DSP at 0x00, and a return at PSP 0 reads 0xFF and then 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| swap_i | input | 1 | Exchange accumulator with DSP |
| pc_i | input | 12 | Program counter to save on call |
| flags_i | input | 4 | Flags to save on call |
| data_i | input | 8 | Push byte, or new DSP value on exchange |
| ram_rdata_i | input | 8 | RAM read data, one cycle after read enable |
| ram_addr_o | output | 8 | RAM address |
| ram_we_o | output | 1 | RAM write enable |
| ram_re_o | output | 1 | RAM read enable |
| ram_wdata_o | output | 8 | RAM write data |
| busy_o | output | 1 | Second cycle of a call or return |
| pc_o | output | 12 | Restored program counter |
| ret_done_o | output | 1 | One-cycle pulse: `pc_o` valid |
| pop_data_o | output | 8 | Popped byte |
| pop_done_o | output | 1 | One-cycle pulse: `pop_data_o` valid |
| dsp_o | output | 8 | Current DSP (old value for the accumulator on exchange) |

## Verification
A wrong DSP shows up in the same cycle as the next push or pop, as a RAM address one away from the expected one. It also shows on `dsp_o` one clock after the operation. A wrong PSP cannot be seen until the next call or return, and it then appears in the first address that operation drives. A corrupted saved high byte or a mis-ordered read shows three cycles after the return strobe, as a wrong `pc_o`. A sequencer stuck in its second state shows as `busy_o` held high on a second cycle, with later strobes silently dropped.

// File: rtl/dstk_pkg.sv
package dstk_pkg;
    parameter int unsigned PC_W   = 12;
    parameter int unsigned FLAG_W = 4;
    parameter int unsigned AW     = 8;
    parameter int unsigned DW     = 8;
    localparam int unsigned PC_HI_W = PC_W - DW;

    typedef logic [AW-1:0]     addr_t;
    typedef logic [DW-1:0]     byte_t;
    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [FLAG_W-1:0] flag_t;
    typedef logic [PC_HI_W-1:0] pchi_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_CALL, OP_RET, OP_PUSH, OP_POP, OP_SWAP
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_CALL_HI, ST_RET_LO
    } st_e;

    typedef struct packed {
        logic call;
        logic ret;
        logic push;
        logic pop;
        logic swap;
    } req_t;

    // Second byte of a saved return entry: flags above the upper PC bits.
    function automatic byte_t pack_hi(flag_t f, pc_t pc);
        return {f, pc[PC_W-1:DW]};
    endfunction

    // Fixed priority among simultaneous strobes.
    function automatic op_e pick_op(req_t r);
        if (r.call)      return OP_CALL;
        else if (r.ret)  return OP_RET;
        else if (r.push) return OP_PUSH;
        else if (r.pop)  return OP_POP;
        else if (r.swap) return OP_SWAP;
        return OP_NONE;
    endfunction
endpackage

// File: rtl/dstk_seq.sv
module dstk_seq
    import dstk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  req_t req,
    output op_e  op,
    output st_e  st
);
    st_e st_q;

    // Strobes are taken only when no two-cycle transfer is in flight.
    always_comb begin
        op = OP_NONE;
        if (st_q == ST_IDLE) op = pick_op(req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (op == OP_CALL)     st_q <= ST_CALL_HI;
                    else if (op == OP_RET) st_q <= ST_RET_LO;
                    else                   st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign st = st_q;
endmodule

// File: rtl/dstk_ptrs.sv
module dstk_ptrs
    import dstk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    input  st_e   st,
    input  byte_t load_val,
    output addr_t psp,
    output addr_t dsp
);
    localparam addr_t ENTRY = addr_t'(2);
    localparam addr_t ONE   = addr_t'(1);

    addr_t psp_q, dsp_q;

    // Return-stack pointer moves at the end of the second transfer cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            psp_q <= '0;
        end else if (st == ST_CALL_HI) begin
            psp_q <= psp_q + ENTRY;
        end else if (st == ST_RET_LO) begin
            psp_q <= psp_q - ENTRY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dsp_q <= '0;
        end else begin
            unique case (op)
                OP_PUSH: dsp_q <= dsp_q - ONE;
                OP_POP:  dsp_q <= dsp_q + ONE;
                OP_SWAP: dsp_q <= addr_t'(load_val);
                default: dsp_q <= dsp_q;
            endcase
        end
    end

    assign psp = psp_q;
    assign dsp = dsp_q;
endmodule

// File: rtl/dstk_port.sv
module dstk_port
    import dstk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    input  st_e   st,
    input  addr_t psp,
    input  addr_t dsp,
    input  pc_t   pc,
    input  flag_t flags,
    input  byte_t din,
    input  byte_t rdata,
    output addr_t addr,
    output logic  we,
    output logic  re,
    output byte_t wdata,
    output pc_t   pc_out,
    output logic  ret_done,
    output byte_t pop_data,
    output logic  pop_done
);
    localparam addr_t ONE = addr_t'(1);
    localparam addr_t TWO = addr_t'(2);

    byte_t hi_q;
    pchi_t ret_hi_q;
    logic  ret_fin_q, pop_pend_q, ret_done_q, pop_done_q;
    pc_t   pc_q;
    byte_t pop_q;

    always_comb begin
        addr  = '0;
        we    = 1'b0;
        re    = 1'b0;
        wdata = '0;
        unique case (st)
            ST_CALL_HI: begin
                addr  = psp + ONE;
                we    = 1'b1;
                wdata = hi_q;
            end
            ST_RET_LO: begin
                addr = psp - TWO;
                re   = 1'b1;
            end
            default: begin
                unique case (op)
                    OP_CALL: begin
                        addr  = psp;
                        we    = 1'b1;
                        wdata = pc[DW-1:0];
                    end
                    OP_RET: begin
                        addr = psp - ONE;
                        re   = 1'b1;
                    end
                    OP_PUSH: begin
                        addr  = dsp - ONE;
                        we    = 1'b1;
                        wdata = din;
                    end
                    OP_POP: begin
                        addr = dsp;
                        re   = 1'b1;
                    end
                    default: ;
                endcase
            end
        endcase
    end

    // Upper entry byte is frozen on the strobe cycle for the second write.
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
        end else if (op == OP_CALL) begin
            hi_q <= pack_hi(flags, pc);
        end
    end

    // Read returns: RAM data lags the enable by one cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            ret_hi_q   <= '0;
            ret_fin_q  <= 1'b0;
            pop_pend_q <= 1'b0;
            ret_done_q <= 1'b0;
            pop_done_q <= 1'b0;
            pc_q       <= '0;
            pop_q      <= '0;
        end else begin
            ret_fin_q  <= (st == ST_RET_LO);
            pop_pend_q <= (op == OP_POP);
            ret_done_q <= ret_fin_q;
            pop_done_q <= pop_pend_q;
            if (st == ST_RET_LO) ret_hi_q <= rdata[PC_HI_W-1:0];
            if (ret_fin_q)       pc_q     <= {ret_hi_q, rdata};
            if (pop_pend_q)      pop_q    <= rdata;
        end
    end

    assign pc_out   = pc_q;
    assign ret_done = ret_done_q;
    assign pop_data = pop_q;
    assign pop_done = pop_done_q;
endmodule

// File: rtl/dual_stack_engine.sv
module dual_stack_engine (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        call_i,
    input  logic                        ret_i,
    input  logic                        push_i,
    input  logic                        pop_i,
    input  logic                        swap_i,
    input  logic [dstk_pkg::PC_W-1:0]   pc_i,
    input  logic [dstk_pkg::FLAG_W-1:0] flags_i,
    input  logic [dstk_pkg::DW-1:0]     data_i,
    input  logic [dstk_pkg::DW-1:0]     ram_rdata_i,
    output logic [dstk_pkg::AW-1:0]     ram_addr_o,
    output logic                        ram_we_o,
    output logic                        ram_re_o,
    output logic [dstk_pkg::DW-1:0]     ram_wdata_o,
    output logic                        busy_o,
    output logic [dstk_pkg::PC_W-1:0]   pc_o,
    output logic                        ret_done_o,
    output logic [dstk_pkg::DW-1:0]     pop_data_o,
    output logic                        pop_done_o,
    output logic [dstk_pkg::AW-1:0]     dsp_o
);
    import dstk_pkg::*;

    req_t  req;
    op_e   op;
    st_e   st;
    addr_t psp, dsp;

    assign req = '{call: call_i, ret: ret_i, push: push_i, pop: pop_i, swap: swap_i};

    dstk_seq u_seq (
        .clk (clk),
        .rst (rst),
        .req (req),
        .op  (op),
        .st  (st)
    );

    dstk_ptrs u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .st       (st),
        .load_val (data_i),
        .psp      (psp),
        .dsp      (dsp)
    );

    dstk_port u_port (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .st       (st),
        .psp      (psp),
        .dsp      (dsp),
        .pc       (pc_i),
        .flags    (flags_i),
        .din      (data_i),
        .rdata    (ram_rdata_i),
        .addr     (ram_addr_o),
        .we       (ram_we_o),
        .re       (ram_re_o),
        .wdata    (ram_wdata_o),
        .pc_out   (pc_o),
        .ret_done (ret_done_o),
        .pop_data (pop_data_o),
        .pop_done (pop_done_o)
    );

    assign busy_o = (st != ST_IDLE);
    assign dsp_o  = dsp;
endmodule

// File: rtl/dstk_chk.sv
module dstk_chk (
    input logic                        clk,
    input logic                        rst,
    input logic                        call_i,
    input logic                        ret_i,
    input logic                        push_i,
    input logic                        pop_i,
    input logic                        swap_i,
    input logic [dstk_pkg::PC_W-1:0]   pc_i,
    input logic [dstk_pkg::FLAG_W-1:0] flags_i,
    input logic [dstk_pkg::DW-1:0]     data_i,
    input logic [dstk_pkg::AW-1:0]     ram_addr_o,
    input logic                        ram_we_o,
    input logic                        ram_re_o,
    input logic [dstk_pkg::DW-1:0]     ram_wdata_o,
    input logic                        busy_o,
    input logic                        ret_done_o,
    input logic                        pop_done_o,
    input logic [dstk_pkg::AW-1:0]     dsp_o
);
    import dstk_pkg::*;

    logic acc_call, acc_ret, acc_push, acc_pop, acc_swap;
    assign acc_call = call_i & ~busy_o;
    assign acc_ret  = ret_i & ~call_i & ~busy_o;
    assign acc_push = push_i & ~ret_i & ~call_i & ~busy_o;
    assign acc_pop  = pop_i & ~push_i & ~ret_i & ~call_i & ~busy_o;
    assign acc_swap = swap_i & ~pop_i & ~push_i & ~ret_i & ~call_i & ~busy_o;

    AST_CALL_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
        acc_call |-> ram_we_o && !ram_re_o && ram_wdata_o == pc_i[DW-1:0]); // R1
    AST_CALL_HIGH_BYTE: assert property (@(posedge clk) disable iff (rst)
        acc_call |=> busy_o && ram_we_o && ram_addr_o == $past(ram_addr_o) + 8'd1
                     && ram_wdata_o == {$past(flags_i), $past(pc_i[PC_W-1:DW])}); // R1
    AST_RET_SECOND_READ: assert property (@(posedge clk) disable iff (rst)
        acc_ret |=> busy_o && ram_re_o && ram_addr_o == $past(ram_addr_o) - 8'd1); // R2
    AST_RET_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        acc_ret |=> ##2 ret_done_o); // R2
    AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (rst)
        acc_push |-> ram_we_o && ram_addr_o == dsp_o - 8'd1 && ram_wdata_o == data_i); // R3
    AST_PUSH_DSP_STEP: assert property (@(posedge clk) disable iff (rst)
        acc_push |=> dsp_o == $past(dsp_o) - 8'd1); // R3
    AST_POP_ADDR: assert property (@(posedge clk) disable iff (rst)
        acc_pop |-> ram_re_o && !ram_we_o && ram_addr_o == dsp_o); // R4
    AST_POP_DSP_STEP: assert property (@(posedge clk) disable iff (rst)
        acc_pop |=> dsp_o == $past(dsp_o) + 8'd1); // R4
    AST_POP_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        acc_pop |=> ##1 pop_done_o); // R4
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> dsp_o == '0 && !busy_o && !ret_done_o && !pop_done_o); // R5
    AST_SWAP_NO_RAM: assert property (@(posedge clk) disable iff (rst)
        acc_swap |-> !ram_we_o && !ram_re_o); // R6
    AST_SWAP_LOAD: assert property (@(posedge clk) disable iff (rst)
        acc_swap |=> dsp_o == $past(data_i)); // R6
    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !busy_o); // R7
    AST_BUSY_HOLDS_DSP: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(dsp_o)); // R7
    AST_ONE_RAM_DIR: assert property (@(posedge clk) disable iff (rst)
        !(ram_we_o && ram_re_o)); // R8
endmodule

bind dual_stack_engine dstk_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .swap_i      (swap_i),
    .pc_i        (pc_i),
    .flags_i     (flags_i),
    .data_i      (data_i),
    .ram_addr_o  (ram_addr_o),
    .ram_we_o    (ram_we_o),
    .ram_re_o    (ram_re_o),
    .ram_wdata_o (ram_wdata_o),
    .busy_o      (busy_o),
    .ret_done_o  (ret_done_o),
    .pop_done_o  (pop_done_o),
    .dsp_o       (dsp_o)
);

// File: tb/dual_stack_engine_tb_top.sv
module dual_stack_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call_i = 0, ret_i = 0, push_i = 0, pop_i = 0, swap_i = 0;
    logic [11:0] pc_i = '0;
    logic [3:0]  flags_i = '0;
    logic [7:0]  data_i = '0;
    logic [7:0]  ram_rdata_i = '0;
    logic [7:0]  ram_addr_o, ram_wdata_o, pop_data_o, dsp_o;
    logic        ram_we_o, ram_re_o, busy_o, ret_done_o, pop_done_o;
    logic [11:0] pc_o;

    logic [7:0]  mem [256];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [7:0]  psp_exp = 8'h00;
    logic [7:0]  dsp_exp = 8'h00;

    always #4 clk = ~clk;

    dual_stack_engine dut_i (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i), .push_i(push_i),
        .pop_i(pop_i), .swap_i(swap_i), .pc_i(pc_i), .flags_i(flags_i),
        .data_i(data_i), .ram_rdata_i(ram_rdata_i), .ram_addr_o(ram_addr_o),
        .ram_we_o(ram_we_o), .ram_re_o(ram_re_o), .ram_wdata_o(ram_wdata_o),
        .busy_o(busy_o), .pc_o(pc_o), .ret_done_o(ret_done_o),
        .pop_data_o(pop_data_o), .pop_done_o(pop_done_o), .dsp_o(dsp_o)
    );

    // Synchronous RAM model, one cycle read latency.
    always @(posedge clk) begin
        if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
        if (ram_re_o) ram_rdata_i <= mem[ram_addr_o];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
        #1;
    endtask

    task automatic do_push(input logic [7:0] v);
        push_i = 1; data_i = v; #1;
        chk("R3 push we", {31'b0, ram_we_o}, 1);
        chk("R3 push addr", ram_addr_o, 8'(dsp_exp - 8'd1));
        chk("R3 push data", ram_wdata_o, v);
        next_cycle();
        push_i = 0; dsp_exp = dsp_exp - 8'd1;
        chk("R3 dsp after push", dsp_o, dsp_exp);
    endtask

    task automatic do_pop(input logic [7:0] v);
        pop_i = 1; #1;
        chk("R4 pop re", {31'b0, ram_re_o}, 1);
        chk("R4 pop addr", ram_addr_o, dsp_exp);
        next_cycle();
        pop_i = 0; dsp_exp = dsp_exp + 8'd1;
        chk("R4 dsp after pop", dsp_o, dsp_exp);
        chk("R4 pop_done early", {31'b0, pop_done_o}, 0);
        next_cycle();
        chk("R4 pop_done", {31'b0, pop_done_o}, 1);
        chk("R4 pop data", pop_data_o, v);
    endtask

    task automatic do_call(input logic [11:0] pc, input logic [3:0] fl);
        call_i = 1; pc_i = pc; flags_i = fl; #1;
        chk("R1 call lo addr", ram_addr_o, psp_exp);
        chk("R1 call lo data", ram_wdata_o, pc[7:0]);
        chk("R1 call lo we", {31'b0, ram_we_o}, 1);
        next_cycle();
        call_i = 0; pc_i = '0; flags_i = '0; #1;
        chk("R7 busy in second cycle", {31'b0, busy_o}, 1);
        chk("R1 call hi addr", ram_addr_o, 8'(psp_exp + 8'd1));
        chk("R1 call hi data", ram_wdata_o, {fl, pc[11:8]});
        next_cycle();
        psp_exp = psp_exp + 8'd2;
        chk("R7 busy drops", {31'b0, busy_o}, 0);
    endtask

    task automatic do_ret(input logic [11:0] pc_exp, input logic also_push);
        ret_i = 1; push_i = also_push; data_i = 8'hEE; #1;
        chk("R2 ret first addr", ram_addr_o, 8'(psp_exp - 8'd1));
        chk("R2 ret first re", {31'b0, ram_re_o}, 1);
        chk("R8 ret beats push", {31'b0, ram_we_o}, 0);
        next_cycle();
        ret_i = 0; push_i = 0;
        chk("R2 ret second addr", ram_addr_o, 8'(psp_exp - 8'd2));
        chk("R2 ret second re", {31'b0, ram_re_o}, 1);
        next_cycle();
        chk("R2 ret_done early", {31'b0, ret_done_o}, 0);
        next_cycle();
        psp_exp = psp_exp - 8'd2;
        chk("R2 ret_done", {31'b0, ret_done_o}, 1);
        chk("R2 restored pc, flags dropped", pc_o, pc_exp);
        next_cycle();
        chk("R2 ret_done pulse", {31'b0, ret_done_o}, 0);
        chk("R8 dsp untouched by losing push", dsp_o, dsp_exp);
    endtask

    task automatic do_swap(input logic [7:0] v);
        swap_i = 1; data_i = v; #1;
        chk("R6 dsp visible before swap", dsp_o, dsp_exp);
        chk("R6 swap no ram", {30'b0, ram_we_o, ram_re_o}, 0);
        next_cycle();
        swap_i = 0; dsp_exp = v;
        chk("R6 dsp after swap", dsp_o, dsp_exp);
    endtask

    task automatic t_reset();
        chk("R5 dsp reset", dsp_o, 0);
        chk("R5 busy reset", {31'b0, busy_o}, 0);
        chk("R5 done reset", {30'b0, ret_done_o, pop_done_o}, 0);
    endtask

    task automatic t_first_push();
        do_push(8'h3C);   // R5: lands at 0xFF
        chk("R5 first push at top", {24'b0, mem[8'hFF]}, 8'h3C);
        do_pop(8'h3C);
    endtask

    task automatic t_lifo();
        do_push(8'h11); do_push(8'h22); do_push(8'h33);
        do_pop(8'h33); do_pop(8'h22); do_pop(8'h11);
    endtask

    task automatic t_call_ret();
        do_call(12'h5A3, 4'hC);
        do_call(12'h0F1, 4'h3);
        do_ret(12'h0F1, 1'b0);
        do_ret(12'h5A3, 1'b0);
    endtask

    task automatic t_busy_ignore();
        call_i = 1; pc_i = 12'h7B4; flags_i = 4'h9;
        next_cycle();
        call_i = 0; push_i = 1; data_i = 8'h77; #1;
        chk("R7 busy ignores push addr", ram_addr_o, 8'(psp_exp + 8'd1));
        chk("R7 busy ignores push data", ram_wdata_o, 8'h97);
        next_cycle();
        push_i = 0; psp_exp = psp_exp + 8'd2;
        chk("R7 dsp unchanged", dsp_o, dsp_exp);
        do_ret(12'h7B4, 1'b1);
    endtask

    task automatic t_priority();
        call_i = 1; push_i = 1; pop_i = 1; pc_i = 12'h2C8; flags_i = 4'h5; data_i = 8'h44; #1;
        chk("R8 call wins addr", ram_addr_o, psp_exp);
        chk("R8 call wins data", ram_wdata_o, 8'hC8);
        next_cycle();
        call_i = 0; push_i = 0; pop_i = 0;
        next_cycle();
        psp_exp = psp_exp + 8'd2;
        chk("R8 dsp unchanged by losers", dsp_o, dsp_exp);
        push_i = 1; pop_i = 1; swap_i = 1; data_i = 8'h66; #1;
        chk("R8 push beats pop", {30'b0, ram_we_o, ram_re_o}, 2'b10);
        next_cycle();
        push_i = 0; pop_i = 0; swap_i = 0; dsp_exp = dsp_exp - 8'd1;
        chk("R8 push took effect", dsp_o, dsp_exp);
        pop_i = 1; swap_i = 1; data_i = 8'h10; #1;
        chk("R8 pop beats swap", {30'b0, ram_we_o, ram_re_o}, 2'b01);
        next_cycle();
        pop_i = 0; swap_i = 0; dsp_exp = dsp_exp + 8'd1;
        chk("R8 pop took effect", dsp_o, dsp_exp);
        do_ret(12'h2C8, 1'b0);
    endtask

    task automatic t_swap();
        do_swap(8'h20);
        do_push(8'h5E);   // R6: relocated stack writes 0x1F
        chk("R6 relocated push", {24'b0, mem[8'h1F]}, 8'h5E);
        do_pop(8'h5E);
    endtask

    task automatic t_wrap();
        do_swap(8'hFF);
        pop_i = 1; #1;
        chk("R9 pop at 0xFF addr", ram_addr_o, 8'hFF);
        next_cycle();
        pop_i = 0; dsp_exp = 8'h00;
        chk("R9 dsp wraps to 0", dsp_o, 8'h00);
        next_cycle();
        do_push(8'h9A); do_push(8'h4B);
        do_ret(12'hA4B, 1'b0);  // R9: reads 0xFF then 0xFE
        chk("R9 psp wrapped", {24'b0, psp_exp}, 8'hFE);
        do_call(12'h123, 4'h1);
        chk("R9 call wrote 0xFF", {24'b0, mem[8'hFF]}, 8'h11);
        do_call(12'h456, 4'h2);  // back at PSP 0
        do_ret(12'h456, 1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        next_cycle();
        t_reset();
        t_first_push();
        t_lifo();
        t_call_ret();
        t_busy_ignore();
        t_priority();
        t_swap();
        t_wrap();
        next_cycle();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end
endmodule